// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the slave side of a three-wire serial memory bus: chip select, serial clock and serial data in, with serial data out. Behind it sits a 1 kbit array held in flip-flops. By default the array is 64 words of 16 bits. A parameter changes it to 128 bytes of 8 bits. All bus pins are taken as synchronous to the system clock. The block finds serial clock rising edges by comparing each sample with the one before.

A transaction opens with chip select high and a start bit of 1. A 2-bit opcode and an address follow, and then any data. The block supports reads that keep streaming as long as clocks arrive, and writes that accept a page of consecutive units. It also supports erasing one location, erasing the whole array, filling the whole array with one value, and setting or clearing a write-enable latch.

Every change to the array is held until chip select falls. The change then runs as a self-timed busy cycle whose length is counted in system clocks. During that cycle the data-out pin reports ready or busy whenever chip select is high.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, every location reads as all ones, the write-enable latch is clear, and the output enable is low while chip select is low.
- R2: A command is a 1 start bit, then a 2-bit opcode, then the address MSB first (6 bits for x16, 7 bits for x8). Zeros before the start bit are skipped. Opcode 10 is read, 01 is write and 11 is erase. Opcode 00 is a special command chosen by the two address MSBs: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: On a read, data out goes to 0 at the serial clock edge that samples the last address bit. Each later rising edge then presents one data bit, MSB first.
- R4: If serial clocks continue on a read, the following units come from successively higher addresses, and the address wraps from the top of the array to 0.
- R5: Write, erase, erase-all and write-all leave the array unchanged while the write-enable latch is clear. The enable command sets the latch and the disable command clears it. Reads work in either state.
- R6: A write stores its data unit at the addressed location, and only when chip select falls.
- R7: Further data units in a write go to the next addresses. In x16 mode the low 3 address bits wrap from 7 to 0. In x8 mode the low 4 bits wrap from 15 to 0. A unit written twice to the same location keeps the later value.
- R8: Erase sets the addressed location to all ones. Erase-all sets every location to all ones.
- R9: Write-all stores its data unit in every location.
- R10: After a commit, data out reads 0 while chip select is high until CYCLE_CLKS system clocks have passed, and reads 1 after that.
- R11: A selection that starts fewer than MIN_DESEL+1 clocks after chip select fell is ignored. Output enable stays low for that selection and no command is decoded.
- R12: Dropping chip select part-way through a data unit discards the incomplete unit. A write that has received no complete unit changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (power-up) |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock; data sampled on its rising edge |
| diIn | input | 1 | Serial data in |
| doOut | output | 1 | Serial data out: read data, or ready (1) / busy (0) |
| doOe | output | 1 | Output enable for doOut |

## Verification
The hardest states to reach from the ports are those that depend on how long chip select is held low. These are the deselect window before a new selection is accepted, and the busy window after a commit. The bench controls both by counting system clocks between bus actions. It drops and re-raises chip select after one clock to land inside the deselect window. It raises chip select a few clocks after a commit so that busy is still asserted, then waits out the full cycle. Page wrap-around and overwrite are reached by shifting ten words into an eight-word page from a start address in mid-page.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int ADDR_MAX = 7;

  typedef struct packed {
    logic                addrLoad;
    logic [ADDR_MAX-1:0] addrVal;
    logic                rdLoad;
    logic                rdStep;
    logic                wrBit;
    logic                wrWord;
    logic                doWrite;
    logic                doErase;
    logic                doEraseAll;
    logic                doWriteAll;
  } mwStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CMD, ST_READ, ST_WDATA, ST_HOLD, ST_IGNORE
  } mwState_t;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_WRITE, PEND_ERASE, PEND_ERAL, PEND_WRAL
  } mwPend_t;
endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl import mw_pkg::*; #(
  parameter bit BYTE_ORG   = 1'b0,
  parameter int CYCLE_CLKS = 100,
  parameter int MIN_DESEL  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      skIn,
  input  logic      diIn,
  output mwStrobe_t stb,
  output logic      readMode,
  output logic      busy,
  output logic      ignoreSel
);
  localparam int AW     = BYTE_ORG ? 7 : 6;
  localparam int W      = BYTE_ORG ? 8 : 16;
  localparam int CMDLEN = AW + 2;
  localparam int CNTW   = $clog2(W + CMDLEN);
  localparam int BW     = $clog2(CYCLE_CLKS + 1);
  localparam int DW     = $clog2(MIN_DESEL + 1);

  mwState_t          state;
  mwPend_t           pend;
  logic              wen, wordSeen, csPrev, skPrev;
  logic [CNTW-1:0]   cnt;
  logic [CMDLEN-2:0] cmdShift;
  logic [BW-1:0]     busyCnt;
  logic [DW-1:0]     deselCnt;

  logic              skRise, csFall, csRise, lastCmdBit, commitOk;
  logic [CMDLEN-1:0] fullCmd;
  logic [1:0]        opc, sub;
  logic [AW-1:0]     addrBits;

  assign skRise     = skIn & ~skPrev;
  assign csFall     = csPrev & ~csIn;
  assign csRise     = csIn & ~csPrev;
  assign fullCmd    = {cmdShift, diIn};
  assign opc        = fullCmd[CMDLEN-1:CMDLEN-2];
  assign addrBits   = fullCmd[AW-1:0];
  assign sub        = addrBits[AW-1:AW-2];
  assign lastCmdBit = (state == ST_CMD) && skRise && (cnt == CNTW'(CMDLEN - 1));
  assign commitOk   = csFall && wen &&
                      ((((pend == PEND_WRITE) || (pend == PEND_WRAL)) && wordSeen) ||
                       (pend == PEND_ERASE) || (pend == PEND_ERAL));
  assign busy       = (busyCnt != '0);
  assign readMode   = (state == ST_READ);
  assign ignoreSel  = (state == ST_IGNORE);

  always_comb begin
    stb = '0;
    stb.addrVal = ADDR_MAX'(addrBits);
    if (lastCmdBit && (opc != 2'b00)) begin
      stb.addrLoad = 1'b1;
      stb.rdLoad   = (opc == 2'b10);
    end
    if ((state == ST_READ) && skRise) stb.rdStep = 1'b1;
    if ((state == ST_WDATA) && skRise) begin
      stb.wrBit  = 1'b1;
      stb.wrWord = (cnt == CNTW'(W - 1));
    end
    if (commitOk) begin
      stb.doWrite    = (pend == PEND_WRITE);
      stb.doErase    = (pend == PEND_ERASE);
      stb.doEraseAll = (pend == PEND_ERAL);
      stb.doWriteAll = (pend == PEND_WRAL);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pend     <= PEND_NONE;
      wen      <= 1'b0;
      wordSeen <= 1'b0;
      cnt      <= '0;
      cmdShift <= '0;
      busyCnt  <= '0;
      deselCnt <= DW'(MIN_DESEL);
      csPrev   <= 1'b0;
      skPrev   <= 1'b0;
    end else begin
      csPrev <= csIn;
      skPrev <= skIn;
      if (commitOk) busyCnt <= BW'(CYCLE_CLKS);
      else if (busy) busyCnt <= busyCnt - 1'b1;
      if (!csIn) begin
        state    <= ST_IDLE;
        pend     <= PEND_NONE;
        wordSeen <= 1'b0;
        if (csFall) deselCnt <= '0;
        else if (deselCnt != DW'(MIN_DESEL)) deselCnt <= deselCnt + 1'b1;
      end else if (csRise) begin
        state <= (deselCnt == DW'(MIN_DESEL)) ? ST_WAIT : ST_IGNORE;
        cnt   <= '0;
      end else if (skRise) begin
        case (state)
          ST_WAIT: if (diIn && !busy) begin
            state <= ST_CMD;
            cnt   <= '0;
          end
          ST_CMD: begin
            cmdShift <= fullCmd[CMDLEN-2:0];
            cnt      <= cnt + 1'b1;
            if (lastCmdBit) begin
              cnt <= '0;
              case (opc)
                2'b10: state <= ST_READ;
                2'b01: begin state <= ST_WDATA; pend <= PEND_WRITE; end
                2'b11: begin state <= ST_HOLD;  pend <= PEND_ERASE; end
                default: case (sub)
                  2'b11:   begin state <= ST_HOLD; wen <= 1'b1; end
                  2'b00:   begin state <= ST_HOLD; wen <= 1'b0; end
                  2'b10:   begin state <= ST_HOLD;  pend <= PEND_ERAL; end
                  default: begin state <= ST_WDATA; pend <= PEND_WRAL; end
                endcase
              endcase
            end
          end
          ST_WDATA: begin
            if (cnt == CNTW'(W - 1)) begin
              cnt      <= '0;
              wordSeen <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doWrite || stb.doErase || stb.doEraseAll || stb.doWriteAll) |-> wen);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doWrite || stb.doErase || stb.doEraseAll || stb.doWriteAll) |=> busy);
  // R10
  no_cmd_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD) |-> !busy);
  // R12
  cs_drop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csIn) |=> (state == ST_IDLE));
endmodule

// File: rtl/mw_data.sv
module mw_data import mw_pkg::*; #(
  parameter bit BYTE_ORG = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  mwStrobe_t stb,
  input  logic      diBit,
  output logic      rdBit
);
  localparam int W     = BYTE_ORG ? 8 : 16;
  localparam int AW    = BYTE_ORG ? 7 : 6;
  localparam int DEPTH = 1 << AW;
  localparam int PB    = BYTE_ORG ? 4 : 3;
  localparam int PAGE  = 1 << PB;
  localparam int CW    = $clog2(W);

  logic [W-1:0]    mem [DEPTH];
  logic [W-1:0]    pageBuf [PAGE];
  logic [PAGE-1:0] pageValid;
  logic [W-1:0]    rdShift, wShift, lastWord, newWord;
  logic [AW-1:0]   addr, nextAddr, loadAddr;
  logic [CW-1:0]   rdCnt;
  logic            unusedAddr;

  assign newWord    = {wShift[W-2:0], diBit};
  assign nextAddr   = addr + 1'b1;
  assign loadAddr   = stb.addrVal[AW-1:0];
  assign unusedAddr = ^stb.addrVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.doEraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.doWriteAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= lastWord;
    end else if (stb.doErase) begin
      mem[addr] <= '1;
    end else if (stb.doWrite) begin
      for (int j = 0; j < PAGE; j++)
        if (pageValid[j]) mem[{addr[AW-1:PB], PB'(j)}] <= pageBuf[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr      <= '0;
      rdShift   <= '0;
      rdCnt     <= '0;
      rdBit     <= 1'b0;
      pageValid <= '0;
      wShift    <= '0;
    end else begin
      if (stb.addrLoad) begin
        addr      <= loadAddr;
        pageValid <= '0;
      end
      if (stb.rdLoad) begin
        rdShift <= mem[loadAddr];
        rdCnt   <= '0;
        rdBit   <= 1'b0;
      end
      if (stb.rdStep) begin
        rdBit <= rdShift[W-1];
        if (rdCnt == CW'(W - 1)) begin
          addr    <= nextAddr;
          rdShift <= mem[nextAddr];
          rdCnt   <= '0;
        end else begin
          rdShift <= rdShift << 1;
          rdCnt   <= rdCnt + 1'b1;
        end
      end
      if (stb.wrBit) wShift <= newWord;
      if (stb.wrWord) begin
        pageValid[addr[PB-1:0]] <= 1'b1;
        addr <= {addr[AW-1:PB], addr[PB-1:0] + 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrWord) begin
      pageBuf[addr[PB-1:0]] <= newWord;
      lastWord              <= newWord;
    end
  end

  // R12
  write_has_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWrite |-> (pageValid != '0));
  // R4
  read_no_load_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdStep && stb.addrLoad));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom import mw_pkg::*; #(
  parameter bit BYTE_ORG   = 1'b0,
  parameter int CYCLE_CLKS = 100,
  parameter int MIN_DESEL  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);
  mwStrobe_t stb;
  logic      readMode, busy, ignoreSel, rdBit;

  mw_ctrl #(.BYTE_ORG(BYTE_ORG), .CYCLE_CLKS(CYCLE_CLKS), .MIN_DESEL(MIN_DESEL)) ctrl_i (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .stb(stb), .readMode(readMode), .busy(busy), .ignoreSel(ignoreSel)
  );

  mw_data #(.BYTE_ORG(BYTE_ORG)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .diBit(diIn), .rdBit(rdBit)
  );

  assign doOe  = csIn && !ignoreSel;
  assign doOut = readMode ? rdBit : !busy;

  // R1
  tristate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |-> !doOe);
endmodule

// File: tb/mw_eeprom_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_tb_top;
  localparam int W = 16, AW = 6, DEPTH = 64, CYC = 100, DES = 4;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic doOut, doOe;
  int nChk = 0, nErr = 0;
  bit finished = 1'b0;
  logic [W-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  mw_eeprom #(.BYTE_ORG(1'b0), .CYCLE_CLKS(CYC), .MIN_DESEL(DES)) dut_i (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doOut(doOut), .doOe(doOe)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sk = 1'b0; di = b; tick(2);
    sk = 1'b1; tick(2);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic csUp();
    sk = 1'b0; cs = 1'b1; tick(2);
  endtask

  task automatic csDown();
    sk = 1'b0; cs = 1'b0; tick(DES + 2);
  endtask

  task automatic startCmd(input logic [1:0] op, input logic [AW-1:0] a);
    csUp();
    sendBit(1'b1);
    sendBits(32'(op), 2);
    sendBits(32'(a), AW);
  endtask

  task automatic waitDone();
    csUp(); tick(CYC); csDown();
  endtask

  task automatic special(input logic [1:0] sel);
    startCmd(2'b00, {sel, 4'b0000});
    csDown();
  endtask

  task automatic readRun(input int a, input int n, input string req);
    logic [W-1:0] w;
    startCmd(2'b10, AW'(a));
    chk("R3", "dummy bit", 32'(doOut), 32'd0);
    for (int i = 0; i < n; i++) begin
      w = '0;
      for (int b = 0; b < W; b++) begin
        sendBit(1'b0);
        w = {w[W-2:0], doOut};
      end
      chk(req, $sformatf("word @%0d", (a + i) % DEPTH), 32'(w), 32'(model[(a + i) % DEPTH]));
    end
    csDown();
  endtask

  task automatic writeWord(input int a, input logic [W-1:0] d);
    startCmd(2'b01, AW'(a));
    sendBits(32'(d), W);
    csDown();
    waitDone();
  endtask

  function automatic logic [W-1:0] pat(input int a);
    return W'(a * 16'h1357) ^ 16'hC0DE;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++; nChk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    tick(4); rstN = 1'b1; tick(4);
    // R1: reset state
    chk("R1", "oe while deselected", 32'(doOe), 32'd0);
    readRun(0, DEPTH + 1, "R1");

    // R5: write ignored before enable
    writeWord(5, 16'h1234);
    readRun(5, 1, "R5");

    // R10: busy then ready after a commit
    special(2'b11);
    startCmd(2'b01, AW'(0));
    sendBits(32'(pat(0)), W);
    csDown();
    model[0] = pat(0);
    csUp();
    chk("R10", "busy status", 32'(doOut), 32'd0);
    chk("R10", "oe while busy", 32'(doOe), 32'd1);
    tick(CYC);
    chk("R10", "ready status", 32'(doOut), 32'd1);
    csDown();

    // R6: single-word writes across the whole array
    for (int a = 1; a < DEPTH; a++) begin
      writeWord(a, pat(a));
      model[a] = pat(a);
    end
    readRun(0, DEPTH, "R6");
    // R4: continuous read wraps past the top
    readRun(60, 8, "R4");

    // R2: leading zeros before start bit
    csUp();
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    sendBits(32'b10, 2); sendBits(32'd9, AW);
    chk("R2", "dummy after zeros", 32'(doOut), 32'd0);
    begin
      logic [W-1:0] w;
      w = '0;
      for (int b = 0; b < W; b++) begin sendBit(1'b0); w = {w[W-2:0], doOut}; end
      chk("R2", "word after zeros", 32'(w), 32'(model[9]));
    end
    csDown();

    // R7: page write from mid-page, ten words into an eight-word page
    startCmd(2'b01, AW'(13));
    for (int k = 0; k < 10; k++) begin
      sendBits(32'(16'hA000 + k), W);
      model[8 + ((5 + k) % 8)] = 16'hA000 + W'(k);
    end
    csDown();
    waitDone();
    readRun(6, 12, "R7");

    // R8: single erase
    startCmd(2'b11, AW'(20)); csDown(); waitDone();
    model[20] = '1;
    readRun(19, 3, "R8");

    // R12: incomplete data unit discarded
    startCmd(2'b01, AW'(21));
    sendBits(32'h3FF, 10);
    csDown(); waitDone();
    readRun(21, 1, "R12");

    // R5: disable blocks erase and write, reads still work
    special(2'b00);
    startCmd(2'b11, AW'(21)); csDown(); waitDone();
    writeWord(22, 16'h0000);
    readRun(20, 3, "R5");

    // R9: write-all
    special(2'b11);
    startCmd(2'b00, 6'b010000);
    sendBits(32'h5A3C, W);
    csDown(); waitDone();
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h5A3C;
    readRun(0, DEPTH, "R9");

    // R8: erase-all
    special(2'b10);
    waitDone();
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    readRun(0, DEPTH, "R8");

    // R11: reselect inside the deselect window is ignored
    cs = 1'b1; tick(2);
    cs = 1'b0; tick(1);
    cs = 1'b1; tick(2);
    chk("R11", "oe on early reselect", 32'(doOe), 32'd0);
    sendBit(1'b1); sendBits(32'b01, 2); sendBits(32'd3, AW);
    sendBits(32'h0000, W);
    chk("R11", "oe after ignored bits", 32'(doOe), 32'd0);
    csDown(); waitDone();
    readRun(3, 1, "R11");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule